// File: doc/BRIEF.md
# Two-Slot Expansion Bus Mode Resolver

This block chooses a single protocol mode and clock speed for a secondary expansion bus shared by two card slots. Each slot reports three things: whether a card is fitted, whether that card can run the extended-protocol (PCI-X) mode, and the fastest clock it accepts. The speed is a 2-bit code. The block captures these reports while the bus is held in reset. When that reset is released, it resolves one bus setting from the captured reports.

The resolved protocol mode and clock-select code are registered on the clock edge where bus reset is released. A valid flag follows one cycle later. The mode and speed then stay fixed, whatever the slot inputs do, until bus reset is asserted again. A read-only status word packs the captured presence bits, the mode, the speed code and the valid flag, so that the bus-clock generator and the configuration logic can read them.

Top module: `xbus_mode_resolver`

## Requirements
- R1: After the asynchronous reset, and whenever `bus_rst_n` is low, `bus_pcix` is 0, `bus_spd_sel` is 0 and `cfg_valid` is 0.
- R2: Speed codes are 0 = 33 MHz, 1 = 66 MHz, 2 = 100 MHz and 3 = 133 MHz.
  - For slot i, the code is `slot_max_spd[2i+1:2i]`.
  - `bus_pcix` = 1 means PCI-X mode; 0 means conventional PCI mode.
- R3: The slot inputs used for resolution are the values seen at the last clock edge where `bus_rst_n` was low.
- R4: With no card present, the bus resolves to conventional mode at code 0.
- R5: The bus runs in PCI-X mode only when at least one card is present and every present card has `slot_pcix` = 1. A single conventional card forces conventional mode for both slots.
- R6: The resolved speed is the lowest maximum-speed code among the present cards.
- R7: In conventional mode, the resolved speed is capped at code 1 (66 MHz).
- R8: With two cards present, the resolved speed is capped at code 2 (100 MHz). Code 3 is possible only with exactly one card.
- R9: Mode and speed take their resolved values on the first clock edge where `bus_rst_n` is high. `cfg_valid` rises one edge later.
- R10: While `bus_rst_n` stays high, mode and speed do not change, whatever happens on the slot inputs.
- R11: The status word layout is:
  - `status_word[5:4]` = the presence bits captured during reset.
  - `status_word[3]` = mode.
  - `status_word[2:1]` = speed.
  - `status_word[0]` = valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rst_n | input | 1 | Secondary bus reset, active low, synchronous to clk |
| slot_present | input | 2 | Card-fitted bit per slot |
| slot_pcix | input | 2 | PCI-X-capable bit per slot |
| slot_max_spd | input | 4 | Maximum speed code per slot, 2 bits each |
| bus_pcix | output | 1 | Resolved protocol mode (1 = PCI-X) |
| bus_spd_sel | output | 2 | Resolved clock-select code |
| cfg_valid | output | 1 | Resolved settings are stable |
| status_word | output | 6 | Packed presence, mode, speed and valid |

## Verification
The hardest situations to reach are the interactions between caps. Examples are a 133-capable card paired with a slower card, a conventional card next to a PCI-X card, and a slot that reports a speed code while it is empty. The bench reaches all of them by sweeping all 256 combinations of the two slots' presence, capability and speed inputs through a full bus reset cycle. It also checks that changes on the slot inputs after release leave the outputs fixed.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    SPD_33  = 2'd0,
    SPD_66  = 2'd1,
    SPD_100 = 2'd2,
    SPD_133 = 2'd3
  } bus_spd_e;

  localparam int unsigned SPD_W = 2;

  typedef struct packed {
    logic     pcix;
    bus_spd_e spd;
  } bus_cfg_t;
endpackage

// File: rtl/xbus_slot_capture.sv
module xbus_slot_capture
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             present_in,
  input  logic             pcix_in,
  input  logic [SPD_W-1:0] spd_in,
  output logic             present_q,
  output logic             pcix_q,
  output logic [SPD_W-1:0] spd_q
);
  logic             present_d;
  logic             pcix_d;
  logic [SPD_W-1:0] spd_d;

  always_comb begin
    present_d = present_q;
    pcix_d    = pcix_q;
    spd_d     = spd_q;
    if (cap_en) begin
      present_d = present_in;
      pcix_d    = pcix_in;
      spd_d     = spd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= 1'b0;
      pcix_q    <= 1'b0;
      spd_q     <= '0;
    end else begin
      present_q <= present_d;
      pcix_q    <= pcix_d;
      spd_q     <= spd_d;
    end
  end
endmodule

// File: rtl/xbus_cfg_resolve.sv
module xbus_cfg_resolve
  import xbus_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic [NUM_SLOTS-1:0]       present,
  input  logic [NUM_SLOTS-1:0]       pcix_cap,
  input  logic [NUM_SLOTS*SPD_W-1:0] max_spd,
  output bus_cfg_t                   cfg
);
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1);

  logic [CNT_W-1:0] n_cards;
  logic             all_pcix;
  logic [SPD_W-1:0] min_spd;
  logic [SPD_W-1:0] capped;

  always_comb begin
    n_cards  = '0;
    all_pcix = 1'b1;
    min_spd  = SPD_133;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (present[i]) begin
        n_cards = n_cards + 1'b1;
        if (!pcix_cap[i]) all_pcix = 1'b0;
        if (max_spd[i*SPD_W +: SPD_W] < min_spd) min_spd = max_spd[i*SPD_W +: SPD_W];
      end
    end
  end

  always_comb begin
    cfg    = '{pcix: 1'b0, spd: SPD_33};
    capped = min_spd;
    if (n_cards > 1 && capped > SPD_100) capped = SPD_100;
    if (n_cards != 0) begin
      cfg.pcix = all_pcix;
      if (!all_pcix && capped > SPD_66) capped = SPD_66;
      cfg.spd = bus_spd_e'(capped);
    end
  end
endmodule

// File: rtl/xbus_mode_resolver.sv
module xbus_mode_resolver
  import xbus_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned STAT_W   = NUM_SLOTS + 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_rst_n,
  input  logic [NUM_SLOTS-1:0]       slot_present,
  input  logic [NUM_SLOTS-1:0]       slot_pcix,
  input  logic [NUM_SLOTS*SPD_W-1:0] slot_max_spd,
  output logic                       bus_pcix,
  output logic [SPD_W-1:0]           bus_spd_sel,
  output logic                       cfg_valid,
  output logic [STAT_W-1:0]          status_word
);
  logic [NUM_SLOTS-1:0]       pres_q;
  logic [NUM_SLOTS-1:0]       cap_q;
  logic [NUM_SLOTS*SPD_W-1:0] spd_q;
  bus_cfg_t                   res_cfg;

  logic     in_rst_q, in_rst_d;
  logic     valid_q, valid_d;
  bus_cfg_t cfg_q, cfg_d;
  logic     cfg_en;

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      xbus_slot_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (~bus_rst_n),
        .present_in (slot_present[g]),
        .pcix_in    (slot_pcix[g]),
        .spd_in     (slot_max_spd[g*SPD_W +: SPD_W]),
        .present_q  (pres_q[g]),
        .pcix_q     (cap_q[g]),
        .spd_q      (spd_q[g*SPD_W +: SPD_W])
      );
    end
  endgenerate

  xbus_cfg_resolve #(.NUM_SLOTS(NUM_SLOTS)) u_res (
    .present  (pres_q),
    .pcix_cap (cap_q),
    .max_spd  (spd_q),
    .cfg      (res_cfg)
  );

  // Control: the lock edge is the first edge with bus reset high
  always_comb begin
    in_rst_d = in_rst_q;
    valid_d  = valid_q;
    cfg_en   = 1'b0;
    cfg_d    = cfg_q;
    if (!bus_rst_n) begin
      in_rst_d = 1'b1;
      valid_d  = 1'b0;
      cfg_en   = 1'b1;
      cfg_d    = '{pcix: 1'b0, spd: SPD_33};
    end else if (in_rst_q) begin
      in_rst_d = 1'b0;
      cfg_en   = 1'b1;
      cfg_d    = res_cfg;
    end else begin
      valid_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rst_q <= 1'b1;
      valid_q  <= 1'b0;
      cfg_q    <= '{pcix: 1'b0, spd: SPD_33};
    end else begin
      in_rst_q <= in_rst_d;
      valid_q  <= valid_d;
      if (cfg_en) cfg_q <= cfg_d;
    end
  end

  assign bus_pcix    = cfg_q.pcix;
  assign bus_spd_sel = cfg_q.spd;
  assign cfg_valid   = valid_q;
  assign status_word = {pres_q, cfg_q.pcix, cfg_q.spd, valid_q};

  // R1
  bus_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |=> (!cfg_valid && !bus_pcix && bus_spd_sel == SPD_33));
  // R7
  conv_speed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_pcix |-> bus_spd_sel <= SPD_66);
  // R8
  dual_speed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pres_q) > 1 && cfg_valid) |-> bus_spd_sel != SPD_133);
  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> ($past(bus_rst_n) && !$past(cfg_valid)));
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && bus_rst_n) |=> ($stable(bus_pcix) && $stable(bus_spd_sel) && cfg_valid));
  // R4
  empty_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_q == '0) |-> (!bus_pcix && bus_spd_sel == SPD_33));
endmodule

// File: tb/test_xbus_mode_resolver.sv
module test_xbus_mode_resolver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_rst_n;
  logic [1:0] slot_present;
  logic [1:0] slot_pcix;
  logic [3:0] slot_max_spd;
  logic       bus_pcix;
  logic [1:0] bus_spd_sel;
  logic       cfg_valid;
  logic [5:0] status_word;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  xbus_mode_resolver i_xbus_mode_resolver (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
    .slot_present(slot_present), .slot_pcix(slot_pcix), .slot_max_spd(slot_max_spd),
    .bus_pcix(bus_pcix), .bus_spd_sel(bus_spd_sel), .cfg_valid(cfg_valid),
    .status_word(status_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_mode(input logic [7:0] v);
    int n = v[0] + v[1];
    if (n == 0) return 0;
    for (int i = 0; i < 2; i++) if (v[i] && !v[2+i]) return 0;
    return 1;
  endfunction

  function automatic int exp_spd(input logic [7:0] v);
    int n  = v[0] + v[1];
    int mn = 3;
    if (n == 0) return 0;
    for (int i = 0; i < 2; i++) begin
      int s = (v >> (4 + 2*i)) & 3;
      if (v[i] && s < mn) mn = s;
    end
    if (n == 2 && mn > 2) mn = 2;
    if (exp_mode(v) == 0 && mn > 1) mn = 1;
    return mn;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_rst_n = 1'b0;
    slot_present = '0; slot_pcix = '0; slot_max_spd = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", cfg_valid, 0);
    chk("R1 mode", bus_pcix, 0);
    chk("R1 spd", bus_spd_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] v = 8'(c);
      int em = exp_mode(v);
      int es = exp_spd(v);
      bus_rst_n = 1'b0;
      slot_present = v[1:0]; slot_pcix = v[3:2]; slot_max_spd = v[7:4];
      @(negedge clk);
      // R1 outputs held cleared in bus reset
      chk("R1 valid in reset", cfg_valid, 0);
      chk("R1 spd in reset", bus_spd_sel, 0);
      // R3 inputs changed on release edge are ignored
      bus_rst_n = 1'b1;
      slot_present = ~v[1:0]; slot_pcix = ~v[3:2]; slot_max_spd = ~v[7:4];
      @(negedge clk);
      // R9 lock edge, valid not yet
      chk("R9 valid lag", cfg_valid, 0);
      // R2 R4 R5 mode
      chk("R5 mode", bus_pcix, em);
      // R6 R7 R8 speed
      chk("R6 speed", bus_spd_sel, es);
      @(negedge clk);
      chk("R9 valid", cfg_valid, 1);
      // R11 status layout
      chk("R11 status", status_word, (v[1:0] << 4) | (em << 3) | (es << 1) | 1);
      slot_present = v[3:2]; slot_pcix = v[7:6]; slot_max_spd = v[5:2];
      repeat (2) @(negedge clk);
      // R10 outputs fixed while bus reset high
      chk("R10 mode hold", bus_pcix, em);
      chk("R10 spd hold", bus_spd_sel, es);
      chk("R10 valid hold", cfg_valid, 1);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule